// File: doc/BRIEF.md
# Flag-Masked Keystream Output Combiner

This block pairs a small phase controller with the 32-bit output combiner of a word-oriented keystream generator. The controller drives two flag registers. Both flags are 0 while the block waits. Both become 1 when a run begins, and they stay at 1 until the run ends. A flag that looks like a control signal, but never changes while output is produced, works as a hidden constant. One flag is replicated across the word width and ANDed into one operand of the output function. This hides the function's real form but does not change any output value.

A run opens with a single-cycle `start` pulse. The run has two phases. The first is a short settle phase that lasts `DWELL_CYC` cycles, and the end-of-run indication is ignored during it. The second phase lasts until `done` is seen. The same run counter also times a warm-up of `WARMUP_CYC` cycles, during which no output is produced. After the warm-up, the block registers one combined word on every clock. The word is the modular sum of the feedback word and the first register word, XORed with the masked second register word. The shift register and the nonlinear state update that feed the three words are outside this block.

Top module: `opq_flagged_combiner`

## Requirements
- R1: After reset, `flag_hi`, `flag_lo` and `word_vld` are all 0.
- R2: When `start` is high at a clock edge while both flags are 0, both flags read 1 after that edge. They remain 1 on every cycle until a run end is accepted.
- R3: A `start` pulse during a run has no effect. It neither restarts the warm-up nor changes the flags.
- R4: If `done` is high at any of the first `DWELL_CYC`-1 edges after the start edge, it is ignored and the flags stay 1.
- R5: If `done` is high at an edge at least `DWELL_CYC` edges after the start edge, the run ends. Both flags and `word_vld` read 0 after that edge. While idle, `done` has no effect.
- R6: No word is produced during the warm-up. `word_vld` first reads 1 after the edge that lies exactly `WARMUP_CYC` edges after the start edge.
- R7: After the warm-up, `word_vld` stays 1 on every cycle until the run ends, so one word is produced per clock.
- R8: The word visible after a loading edge equals ((`fb_word` + `ra_word`) mod 2^32) XOR `rb_word`, taken from the inputs present just before that edge. This holds for operands that include carry wrap-around and all-ones values.
- R9: Whenever `word_vld` is 1, `flag_hi` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Run-begin pulse |
| done | input | 1 | Run-end indication |
| fb_word | input | 32 | Feedback word from the shift register |
| ra_word | input | 32 | First nonlinear register word |
| rb_word | input | 32 | Second nonlinear register word |
| flag_hi | output | 1 | Flag used as the mask for the combiner |
| flag_lo | output | 1 | Second flag register |
| word_out | output | 32 | Combined output word |
| word_vld | output | 1 | Output word valid |

## Verification
Suppose the flag pair left its run value during a run. The mask would then clear the second register word, and the output would differ from the unmasked function on the very next loaded word, whenever that operand is non-zero. Suppose instead the run counter were off by one. `word_vld` would then rise one edge too early or too late, and a premature or ignored run end would show up in the flags on the edge that samples `done`. Random operands make masked and unmasked results differ on almost every word. This turns any flag fault during output into a mismatch within one cycle.

// File: rtl/opq_pkg.sv
package opq_pkg;
   typedef logic [1:0] flag_pair_t;
   localparam flag_pair_t FLAGS_IDLE = 2'b00;
   localparam flag_pair_t FLAGS_RUN  = 2'b11;
endpackage

// File: rtl/opq_seq_ctl.sv
module opq_seq_ctl #(
   parameter int WARMUP_CYC = 32,
   parameter int DWELL_CYC  = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       done_i,
   output logic [1:0] flags_o,
   output logic       load_o
);
   import opq_pkg::*;
   localparam int CW = $clog2(WARMUP_CYC + 1);
   localparam logic [CW-1:0] CNT_WARM  = CW'(WARMUP_CYC);
   localparam logic [CW-1:0] CNT_DWELL = CW'(DWELL_CYC);
   localparam logic [CW-1:0] CNT_ONE   = CW'(1);

   generate
      if (DWELL_CYC < 1 || DWELL_CYC >= WARMUP_CYC) begin : g_bad_dwell
         $error("opq_seq_ctl: DWELL_CYC must lie in 1..WARMUP_CYC-1");
      end
   endgenerate

   flag_pair_t       flags_q;
   logic [CW-1:0]    cnt_q;
   logic             active;
   logic             in_tail;

   assign active  = (flags_q != FLAGS_IDLE);
   assign in_tail = active && (cnt_q >= CNT_DWELL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= FLAGS_IDLE;
         cnt_q   <= '0;
      end else if (!active) begin
         if (start_i) begin
            flags_q <= FLAGS_RUN;
            cnt_q   <= CNT_ONE;
         end
      end else if (in_tail && done_i) begin
         flags_q <= FLAGS_IDLE;
         cnt_q   <= '0;
      end else if (cnt_q != CNT_WARM) begin
         cnt_q <= cnt_q + CNT_ONE;
      end
   end

   assign flags_o = flags_q;
   assign load_o  = active && (cnt_q == CNT_WARM) && !done_i;

   // R2: a run only begins on a start pulse
   a_r2_run_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags_q[1]) |-> $past(start_i));
   // R4: an early run end is ignored
   a_r4_early_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (active && cnt_q < CNT_DWELL && done_i) |=> (flags_q == FLAGS_RUN));
   // R5: the flags only drop on an end indication
   a_r5_drop_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flags_q[0]) |-> $past(done_i));
endmodule

// File: rtl/opq_mask_comb.sv
module opq_mask_comb #(
   parameter int WORD_W  = 32,
   parameter bit MASK_EN = 1'b1
) (
   input  logic [WORD_W-1:0] fb_i,
   input  logic [WORD_W-1:0] ra_i,
   input  logic [WORD_W-1:0] rb_i,
   input  logic              mask_flag_i,
   output logic [WORD_W-1:0] y_o
);
   logic [WORD_W-1:0] sum_w;
   logic [WORD_W-1:0] rb_eff;

   assign sum_w = fb_i + ra_i;

   generate
      if (MASK_EN) begin : g_masked
         assign rb_eff = rb_i & {WORD_W{mask_flag_i}};
      end else begin : g_plain
         logic unused_flag;
         assign unused_flag = mask_flag_i;
         assign rb_eff = rb_i;
      end
   endgenerate

   assign y_o = sum_w ^ rb_eff;
endmodule

// File: rtl/opq_out_reg.sv
module opq_out_reg #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [WORD_W-1:0] d_i,
   output logic [WORD_W-1:0] q_o,
   output logic              vld_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o   <= '0;
         vld_o <= 1'b0;
      end else begin
         vld_o <= load_i;
         if (load_i) q_o <= d_i;
      end
   end
endmodule

// File: rtl/opq_flagged_combiner.sv
module opq_flagged_combiner #(
   parameter int WORD_W     = 32,
   parameter int WARMUP_CYC = 32,
   parameter int DWELL_CYC  = 8,
   parameter bit MASK_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              done,
   input  logic [WORD_W-1:0] fb_word,
   input  logic [WORD_W-1:0] ra_word,
   input  logic [WORD_W-1:0] rb_word,
   output logic              flag_hi,
   output logic              flag_lo,
   output logic [WORD_W-1:0] word_out,
   output logic              word_vld
);
   logic [1:0]        flags;
   logic              load;
   logic [WORD_W-1:0] comb;

   opq_seq_ctl #(.WARMUP_CYC(WARMUP_CYC), .DWELL_CYC(DWELL_CYC)) i_ctl (
      .clk(clk), .rst_n(rst_n), .start_i(start), .done_i(done),
      .flags_o(flags), .load_o(load));

   opq_mask_comb #(.WORD_W(WORD_W), .MASK_EN(MASK_EN)) i_comb (
      .fb_i(fb_word), .ra_i(ra_word), .rb_i(rb_word),
      .mask_flag_i(flags[1]), .y_o(comb));

   opq_out_reg #(.WORD_W(WORD_W)) i_oreg (
      .clk(clk), .rst_n(rst_n), .load_i(load), .d_i(comb),
      .q_o(word_out), .vld_o(word_vld));

   assign flag_hi = flags[1];
   assign flag_lo = flags[0];

   // R9: output is only valid while the mask flag is set
   a_r9_valid_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld |-> flag_hi);
   // R8: masked result equals the plain function of the previous inputs
   a_r8_word_value: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld |-> (word_out == (($past(fb_word) + $past(ra_word)) ^ $past(rb_word))));
endmodule

// File: tb/test_opq_flagged_combiner.sv
module test_opq_flagged_combiner;
   localparam int CLK_PERIOD = 10;
   localparam int W      = 32;
   localparam int WARM   = 32;
   localparam int DWELL  = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, done = 1'b0;
   logic [W-1:0] fb = '0, ra = '0, rb = '0;
   logic flag_hi, flag_lo, word_vld;
   logic [W-1:0] word_out;
   int errors = 0, checks = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   opq_flagged_combiner i_opq_flagged_combiner (
      .clk(clk), .rst_n(rst_n), .start(start), .done(done),
      .fb_word(fb), .ra_word(ra), .rb_word(rb),
      .flag_hi(flag_hi), .flag_lo(flag_lo), .word_out(word_out), .word_vld(word_vld));

   function automatic logic [W-1:0] ref_word(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
      logic [W-1:0] s;
      s = a + b;
      return s ^ c;
   endfunction

   task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // one run: start edge is edge 0; done pulses at edges early_k and end_k; extra start at restart_k
   task automatic run(int early_k, int restart_k, int end_k, int tail);
      bit ended = 0;
      @(negedge clk);
      start = 1'b1; done = 1'b0;
      @(posedge clk); #1;
      check("R2 flags set", {flag_hi, flag_lo}, 2'b11);
      for (int k = 1; k <= end_k + tail; k++) begin
         logic [W-1:0] e;
         @(negedge clk);
         start = (k == restart_k);
         done  = (k == early_k) || (k == end_k);
         if (k == WARM) begin fb = '1; ra = 32'd1; rb = '1; end
         else if (k == WARM + 1) begin fb = 32'h8000_0000; ra = 32'h8000_0000; rb = 32'h0; end
         else begin fb = $urandom; ra = $urandom; rb = $urandom; end
         e = ref_word(fb, ra, rb);
         @(posedge clk);
         if (done && !ended && k >= DWELL) ended = 1;
         #1;
         if (k == early_k && k < DWELL)
            check("R4 early done ignored", {flag_hi, flag_lo}, 2'b11);
         else if (k == restart_k)
            check("R3 restart ignored", {flag_hi, flag_lo}, 2'b11);
         else
            check(ended ? "R5 run end" : "R2 flags held", {flag_hi, flag_lo}, ended ? 2'b00 : 2'b11);
         if (k == WARM && !ended)
            check("R6 first valid", word_vld, 1'b1);
         else if (k < WARM)
            check("R6 warm-up silent", word_vld, 1'b0);
         else
            check(ended ? "R5 valid cleared" : "R7 one word per clock", word_vld, !ended);
         if (word_vld) begin
            check("R8 word value", word_out, e);
            check("R9 valid implies flag", flag_hi, 1'b1);
         end
      end
      @(negedge clk);
      start = 1'b0; done = 1'b0;
   endtask

   initial begin
      void'($urandom(32'h5eed_0017));
      #(CLK_PERIOD*2 + 1);
      check("R1 reset flags", {flag_hi, flag_lo}, 2'b00);
      check("R1 reset valid", word_vld, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      done = 1'b1;
      @(posedge clk); #1;
      check("R5 idle done no effect", {flag_hi, flag_lo, word_vld}, 3'b000);
      run(3, 10, 60, 3);
      run(DWELL - 1, 0, DWELL, 2);
      run(0, 40, WARM, 2);
      run(5, 0, 20, 2);
      for (int i = 0; i < 5; i++) run(0, 0, WARM + 1 + ($urandom % 200), 2);
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule